// File: doc/BRIEF.md
# Per-Subarray Write Aggregation Buffer

This block sits between the cache controller and a row of power-gated cache subarrays. Cache-miss fills and dirty writebacks arrive on the write port with a subarray index, an address and a data word. The block does not forward them straight away. Each write is parked in a small buffer set that belongs to its target subarray. A subarray therefore stays asleep while the writes meant for it pile up, and it is woken once to take them as a single burst.

A buffer set is emptied toward its subarray in two cases: when it fills up, or when a demand read addresses that subarray. A demand read also looks up the buffer set of its subarray, and the block reports a registered hit flag and the buffered data. Draining runs on a separate lane for each subarray, one entry per cycle, in the order the entries were first written. While a set drains, new writes aimed at that subarray are held off by deasserting the write-ready output. Writes to the other subarrays carry on as normal.

Top module: `wab_top`

## Requirements
- R1: Every subarray has its own buffer set. While one set drains, a write to a different subarray is accepted (wr_ready_o high) and stored. A read to a subarray returns only data written to that same subarray.
- R2: A write accepted into a set that is not full is only stored. The drain lane of that subarray stays idle (dr_valid_o bit low) as long as the set holds fewer than DEPTH (8) entries.
- R3: The write that brings a set to DEPTH distinct addresses makes the set start draining on the next cycle. That subarray's busy_o bit is high after the accepting clock edge.
- R4: A read to a set that is not draining and holds at least one entry makes that set start draining on the next cycle. A read to an empty set starts no drain.
- R5: Every read gets a response on the cycle after the request: rd_resp_valid_o is high. If the subarray's set holds the address, rd_hit_o is 1 and rd_rdata_o carries the newest data written to it. Otherwise rd_hit_o is 0 and rd_rdata_o is 0. The lookup uses the contents as they stood before the request cycle.
- R6: A write to an address already held in the set replaces that entry's data where it sits. It takes no new slot, so repeated writes to the same address never fill the set.
- R7: A drain presents one entry per cycle on the subarray's lane (dr_valid_o bit, dr_addr_o and dr_data_o slice i). Entries leave in the order their addresses were first written. The lane is valid for exactly as many cycles as the set held entries.
- R8: While a set drains, wr_ready_o is low whenever wr_sub_i selects that set, and a write offered then is not stored.
- R9: On the clock edge that completes a drain, the set becomes empty and its busy_o bit falls. A later read of an address that was drained misses.
- R10: After reset every set is empty. busy_o, dr_valid_o and rd_resp_valid_o are all low, and wr_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Fill or writeback offered |
| wr_ready_o | output | 1 | Target set can accept the write |
| wr_sub_i | input | SUB_W | Target subarray of the write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_valid_i | input | 1 | Demand read request |
| rd_sub_i | input | SUB_W | Subarray of the read |
| rd_addr_i | input | ADDR_W | Read address |
| rd_resp_valid_o | output | 1 | Lookup response, one cycle after the request |
| rd_hit_o | output | 1 | Buffered copy found |
| rd_rdata_o | output | DATA_W | Buffered data, zero on a miss |
| dr_valid_o | output | NUM_SUB | Drain lane valid, one bit per subarray |
| dr_addr_o | output | NUM_SUB*ADDR_W | Drain addresses, slice i for subarray i |
| dr_data_o | output | NUM_SUB*DATA_W | Drain data, slice i for subarray i |
| busy_o | output | NUM_SUB | Set is draining |

## Verification
The bench first fills a set to one entry short of full and checks that it stays quiet. This catches a design that drains one entry early or late. It then overwrites an address that is already held and confirms that no slot was used, that the newest value is the one returned, and that the same value is the one drained; a design that appended the write would start draining too soon or emit the stale word. During a drain the bench offers writes both to the busy subarray and to another one. A design that ignored back-pressure would let the rejected word slip in, and a design with shared buffering would stall the innocent subarray. Reads of an empty set and of addresses that were already drained check that no spurious burst starts and that the occupancy count was cleared.

// File: rtl/wab_pkg.sv
package wab_pkg;
  localparam int unsigned WAB_NUM_SUB = 4;
  localparam int unsigned WAB_DEPTH   = 8;
  localparam int unsigned WAB_ADDR_W  = 16;
  localparam int unsigned WAB_DATA_W  = 32;

  typedef enum logic {
    SET_FILL  = 1'b0,
    SET_DRAIN = 1'b1
  } set_state_e;
endpackage

// File: rtl/wab_set.sv
module wab_set
  import wab_pkg::*;
#(
  parameter  int unsigned DEPTH  = WAB_DEPTH,
  parameter  int unsigned ADDR_W = WAB_ADDR_W,
  parameter  int unsigned DATA_W = WAB_DATA_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  output logic              busy_o,
  output logic              dr_valid_o,
  output logic [ADDR_W-1:0] dr_addr_o,
  output logic [DATA_W-1:0] dr_data_o
);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [PTR_W-1:0]  ptr_q;
  set_state_e        st_q;

  logic [DEPTH-1:0]  live, wr_match, rd_match;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic              accept, wr_hit, go_drain, last_out;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign live[k]     = CNT_W'(k) < cnt_q;
    assign wr_match[k] = live[k] && (addr_q[k] == wr_addr_i);
    assign rd_match[k] = live[k] && (addr_q[k] == rd_addr_i);
  end

  // addresses in a set are unique, so at most one slot matches
  always_comb begin
    wr_idx = '0;
    rd_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (wr_match[k]) wr_idx = PTR_W'(k);
      if (rd_match[k]) rd_idx = PTR_W'(k);
    end
  end

  assign wr_hit   = |wr_match;
  assign accept   = wr_en_i && (st_q == SET_FILL);
  assign cnt_nxt  = cnt_q + CNT_W'(accept && !wr_hit);
  assign go_drain = (st_q == SET_FILL) &&
                    ((cnt_nxt == CNT_W'(DEPTH)) || (rd_en_i && (cnt_nxt != '0)));
  assign last_out = CNT_W'(ptr_q) == (cnt_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SET_FILL;
      cnt_q <= '0;
      ptr_q <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        addr_q[k] <= '0;
        data_q[k] <= '0;
      end
    end else if (st_q == SET_FILL) begin
      if (accept) begin
        if (wr_hit) begin
          data_q[wr_idx] <= wr_data_i;
        end else begin
          addr_q[cnt_q[PTR_W-1:0]] <= wr_addr_i;
          data_q[cnt_q[PTR_W-1:0]] <= wr_data_i;
        end
      end
      cnt_q <= cnt_nxt;
      if (go_drain) begin
        st_q  <= SET_DRAIN;
        ptr_q <= '0;
      end
    end else begin
      if (last_out) begin
        st_q  <= SET_FILL;
        cnt_q <= '0;
        ptr_q <= '0;
      end else begin
        ptr_q <= ptr_q + PTR_W'(1);
      end
    end
  end

  assign busy_o     = (st_q == SET_DRAIN);
  assign dr_valid_o = busy_o;
  assign dr_addr_o  = addr_q[ptr_q];
  assign dr_data_o  = data_q[ptr_q];
  assign hit_o      = |rd_match;
  assign hit_data_o = data_q[rd_idx];

endmodule

// File: rtl/wab_rd_resp.sv
module wab_rd_resp
  import wab_pkg::*;
#(
  parameter int unsigned NUM_SUB = WAB_NUM_SUB,
  parameter int unsigned DATA_W  = WAB_DATA_W,
  parameter int unsigned SUB_W   = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_valid_i,
  input  logic [SUB_W-1:0]          rd_sub_i,
  input  logic [NUM_SUB-1:0]        set_hit_i,
  input  logic [NUM_SUB*DATA_W-1:0] set_data_i,
  output logic                      resp_valid_o,
  output logic                      resp_hit_o,
  output logic [DATA_W-1:0]         resp_data_o
);

  logic              sel_hit;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    sel_hit  = 1'b0;
    sel_data = '0;
    for (int s = 0; s < NUM_SUB; s++) begin
      if (rd_sub_i == SUB_W'(s)) begin
        sel_hit  = set_hit_i[s];
        sel_data = set_data_i[s*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_data_o  <= '0;
    end else begin
      resp_valid_o <= rd_valid_i;
      resp_hit_o   <= rd_valid_i && sel_hit;
      resp_data_o  <= (rd_valid_i && sel_hit) ? sel_data : '0;
    end
  end

endmodule

// File: rtl/wab_top.sv
module wab_top
  import wab_pkg::*;
#(
  parameter  int unsigned NUM_SUB = WAB_NUM_SUB,
  parameter  int unsigned DEPTH   = WAB_DEPTH,
  parameter  int unsigned ADDR_W  = WAB_ADDR_W,
  parameter  int unsigned DATA_W  = WAB_DATA_W,
  localparam int unsigned SUB_W   = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_valid_i,
  output logic                      wr_ready_o,
  input  logic [SUB_W-1:0]          wr_sub_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic                      rd_valid_i,
  input  logic [SUB_W-1:0]          rd_sub_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic                      rd_resp_valid_o,
  output logic                      rd_hit_o,
  output logic [DATA_W-1:0]         rd_rdata_o,
  output logic [NUM_SUB-1:0]        dr_valid_o,
  output logic [NUM_SUB*ADDR_W-1:0] dr_addr_o,
  output logic [NUM_SUB*DATA_W-1:0] dr_data_o,
  output logic [NUM_SUB-1:0]        busy_o
);

  logic [NUM_SUB-1:0]        set_hit;
  logic [NUM_SUB*DATA_W-1:0] set_data;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_set
    wab_set #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_set (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_valid_i && (wr_sub_i == SUB_W'(s))),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (rd_valid_i && (rd_sub_i == SUB_W'(s))),
      .rd_addr_i (rd_addr_i),
      .hit_o     (set_hit[s]),
      .hit_data_o(set_data[s*DATA_W +: DATA_W]),
      .busy_o    (busy_o[s]),
      .dr_valid_o(dr_valid_o[s]),
      .dr_addr_o (dr_addr_o[s*ADDR_W +: ADDR_W]),
      .dr_data_o (dr_data_o[s*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    wr_ready_o = 1'b1;
    for (int s = 0; s < NUM_SUB; s++) begin
      if (wr_sub_i == SUB_W'(s)) wr_ready_o = !busy_o[s];
    end
  end

  wab_rd_resp #(
    .NUM_SUB(NUM_SUB),
    .DATA_W (DATA_W),
    .SUB_W  (SUB_W)
  ) u_rd_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_valid_i  (rd_valid_i),
    .rd_sub_i    (rd_sub_i),
    .set_hit_i   (set_hit),
    .set_data_i  (set_data),
    .resp_valid_o(rd_resp_valid_o),
    .resp_hit_o  (rd_hit_o),
    .resp_data_o (rd_rdata_o)
  );

endmodule

// File: rtl/wab_top_chk.sv
module wab_top_chk #(
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SUB_W   = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_valid_i,
  input logic                      wr_ready_o,
  input logic [SUB_W-1:0]          wr_sub_i,
  input logic                      rd_valid_i,
  input logic [SUB_W-1:0]          rd_sub_i,
  input logic                      rd_resp_valid_o,
  input logic                      rd_hit_o,
  input logic [NUM_SUB-1:0]        busy_o
);

  // R5: every read request is answered on the following cycle
  assert_rd_resp_next_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_resp_valid_o);

  // R4: a hit on an idle set means the set is draining when the answer appears
  assert_hit_starts_drain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_resp_valid_o && rd_hit_o && $past(rd_valid_i && !busy_o[rd_sub_i]))
      |-> busy_o[$past(rd_sub_i)]);

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
    // R3: a drain only starts after a write or read to that subarray
    assert_drain_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o[i]) |->
        $past((wr_valid_i && wr_ready_o && wr_sub_i == SUB_W'(i)) ||
              (rd_valid_i && rd_sub_i == SUB_W'(i))));

    // R8: no write accepted by a draining set
    assert_backpressure_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_i && wr_sub_i == SUB_W'(i) && busy_o[i]) |-> !wr_ready_o);
  end

endmodule

bind wab_top wab_top_chk #(
  .NUM_SUB(NUM_SUB),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .SUB_W  (SUB_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_valid_i     (wr_valid_i),
  .wr_ready_o     (wr_ready_o),
  .wr_sub_i       (wr_sub_i),
  .rd_valid_i     (rd_valid_i),
  .rd_sub_i       (rd_sub_i),
  .rd_resp_valid_o(rd_resp_valid_o),
  .rd_hit_o       (rd_hit_o),
  .busy_o         (busy_o)
);

// File: tb/tb_wab_top.sv
module tb_wab_top;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_valid_i = 1'b0;
  logic              wr_ready_o;
  logic [1:0]        wr_sub_i = '0;
  logic [AW-1:0]     wr_addr_i = '0;
  logic [DW-1:0]     wr_data_i = '0;
  logic              rd_valid_i = 1'b0;
  logic [1:0]        rd_sub_i = '0;
  logic [AW-1:0]     rd_addr_i = '0;
  logic              rd_resp_valid_o, rd_hit_o;
  logic [DW-1:0]     rd_rdata_o;
  logic [NS-1:0]     dr_valid_o, busy_o;
  logic [NS*AW-1:0]  dr_addr_o;
  logic [NS*DW-1:0]  dr_data_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  wab_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_sub_i(wr_sub_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_valid_i(rd_valid_i), .rd_sub_i(rd_sub_i), .rd_addr_i(rd_addr_i),
    .rd_resp_valid_o(rd_resp_valid_o), .rd_hit_o(rd_hit_o), .rd_rdata_o(rd_rdata_o),
    .dr_valid_o(dr_valid_o), .dr_addr_o(dr_addr_o), .dr_data_o(dr_data_o),
    .busy_o(busy_o)
  );

  typedef struct packed {
    logic        is_rd;
    logic [1:0]  sub;
    logic [15:0] addr;
    logic [31:0] data;
    logic        exp_hit;
    logic [31:0] exp_data;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1, 16'h0010, 32'h0000_00A1, 1'b0, 32'h0},
    '{1'b0, 2'd1, 16'h0011, 32'h0000_00A2, 1'b0, 32'h0},
    '{1'b0, 2'd1, 16'h0010, 32'h0000_00A3, 1'b0, 32'h0},
    '{1'b1, 2'd2, 16'h0010, 32'h0,         1'b0, 32'h0},
    '{1'b1, 2'd1, 16'h0010, 32'h0,         1'b1, 32'h0000_00A3},
    '{1'b0, 2'd1, 16'h0012, 32'h0000_00C1, 1'b0, 32'h0},
    '{1'b1, 2'd1, 16'h0011, 32'h0,         1'b0, 32'h0},
    '{1'b0, 2'd3, 16'h0020, 32'h0000_00B1, 1'b0, 32'h0},
    '{1'b1, 2'd3, 16'h0020, 32'h0,         1'b1, 32'h0000_00B1},
    '{1'b1, 2'd0, 16'h0020, 32'h0,         1'b0, 32'h0}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the accepting edge
  task automatic do_write(input logic [1:0] sub, input logic [15:0] addr,
                          input logic [31:0] data);
    wr_valid_i = 1'b1;
    wr_sub_i   = sub;
    wr_addr_i  = addr;
    wr_data_i  = data;
    #1;
    for (int w = 0; w < 100 && !wr_ready_o; w++) begin
      @(negedge clk_i);
      #1;
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  // called at a negedge, returns at the negedge where the response is visible
  task automatic do_read(input logic [1:0] sub, input logic [15:0] addr);
    rd_valid_i = 1'b1;
    rd_sub_i   = sub;
    rd_addr_i  = addr;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int w = 0; w < 100 && busy_o != '0; w++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    // R10 reset state
    chk("R10", "busy in reset", 64'(busy_o), 64'h0);
    do_reset();
    chk("R10", "busy", 64'(busy_o), 64'h0);
    chk("R10", "drain valid", 64'(dr_valid_o), 64'h0);
    chk("R10", "resp valid", 64'(rd_resp_valid_o), 64'h0);
    chk("R10", "wr ready", 64'(wr_ready_o), 64'h1);

    // table walk: R1 R5 R6 R8 R9
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].is_rd) begin
        do_read(VEC[v].sub, VEC[v].addr);
        chk("R5", $sformatf("vec%0d resp valid", v), 64'(rd_resp_valid_o), 64'h1);
        chk("R5", $sformatf("vec%0d hit", v), 64'(rd_hit_o), 64'(VEC[v].exp_hit));
        chk("R5", $sformatf("vec%0d data", v), 64'(rd_rdata_o), 64'(VEC[v].exp_data));
      end else begin
        do_write(VEC[v].sub, VEC[v].addr, VEC[v].data);
      end
    end
    wait_idle();

    // R4 read of an empty set starts no drain
    do_reset();
    do_read(2'd3, 16'h0300);
    chk("R4", "empty read busy", 64'(busy_o[3]), 64'h0);

    // R6 overwrite in place, R2 no drain before full, R7 drain order and length
    for (int k = 0; k < 7; k++) do_write(2'd2, 16'h0200 + 16'(k), 32'(k + 1));
    chk("R2", "no drain at 7 entries", 64'(dr_valid_o), 64'h0);
    do_write(2'd2, 16'h0203, 32'h0000_BEEF);
    do_write(2'd2, 16'h0203, 32'h0000_DEAD);
    chk("R6", "overwrite takes no slot", 64'(busy_o[2]), 64'h0);
    do_read(2'd2, 16'h0203);
    chk("R5", "newest data", 64'(rd_rdata_o), 64'h0000_DEAD);
    chk("R4", "read starts drain", 64'(busy_o[2]), 64'h1);
    begin
      int n;
      n = 0;
      while (dr_valid_o[2] && n < 20) begin
        chk("R7", $sformatf("drain addr %0d", n), 64'(dr_addr_o[2*AW +: AW]),
            64'(16'h0200 + 16'(n)));
        chk("R7", $sformatf("drain data %0d", n), 64'(dr_data_o[2*DW +: DW]),
            (n == 3) ? 64'h0000_DEAD : 64'(n + 1));
        n++;
        @(negedge clk_i);
      end
      chk("R7", "drain length", 64'(n), 64'd7);
    end
    chk("R9", "busy falls", 64'(busy_o[2]), 64'h0);

    // R3 full set drains; R1 other set writable; R8 back-pressure
    for (int k = 0; k < 7; k++) do_write(2'd0, 16'h0100 + 16'(k), 32'h1000 + 32'(k));
    chk("R3", "not busy at 7", 64'(busy_o[0]), 64'h0);
    do_write(2'd0, 16'h0107, 32'h1007);
    chk("R3", "busy after 8th", 64'(busy_o[0]), 64'h1);
    for (int k = 0; k < 8; k++) begin
      if (k == 0) begin
        wr_valid_i = 1'b1; wr_sub_i = 2'd1; wr_addr_i = 16'h0300; wr_data_i = 32'h77;
        #1;
        chk("R1", "other set ready", 64'(wr_ready_o), 64'h1);
      end else if (k == 2) begin
        wr_valid_i = 1'b1; wr_sub_i = 2'd0; wr_addr_i = 16'h0400; wr_data_i = 32'h99;
        #1;
        chk("R8", "busy set not ready", 64'(wr_ready_o), 64'h0);
      end else begin
        wr_valid_i = 1'b0;
      end
      chk("R7", $sformatf("full drain valid %0d", k), 64'(dr_valid_o[0]), 64'h1);
      chk("R7", $sformatf("full drain addr %0d", k), 64'(dr_addr_o[0 +: AW]),
          64'(16'h0100 + 16'(k)));
      @(negedge clk_i);
    end
    wr_valid_i = 1'b0;
    chk("R9", "busy cleared", 64'(busy_o[0]), 64'h0);
    do_read(2'd0, 16'h0400);
    chk("R8", "rejected write absent", 64'(rd_hit_o), 64'h0);
    do_read(2'd0, 16'h0100);
    chk("R9", "drained addr misses", 64'(rd_hit_o), 64'h0);
    chk("R4", "no drain on empty", 64'(busy_o[0]), 64'h0);
    do_read(2'd1, 16'h0300);
    chk("R1", "other set hit", 64'(rd_hit_o), 64'h1);
    chk("R1", "other set data", 64'(rd_rdata_o), 64'h77);
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule